// File: doc/BRIEF.md
# Latched Fault Supervisor with Debounce

This block sequences and protects a two-stage power controller: a power-factor front stage and a quasi-resonant PWM back stage. All of its inputs are digitized comparator flags, each high while its analog condition holds. The block decides when both stages may switch and when they must stop. It latches fatal faults until power is removed. It clamps the front-stage error amplifier during a line sag, and it parks the front stage on light load.

Each fatal fault passes through its own debounce counter before it can latch. The counter length is a parameter, counted in clock cycles. Output over-voltage is the exception: it is counted in qualified samples, and the caller strobes a sample once per switching cycle after the off-time blanking window. The temperature pin has two debounce lengths. The short one applies when the pin is also below the fast level. Line brown-out does not latch. It stops the stages, and the supply then hiccups until line recovery and a fresh turn-on crossing allow a restart.

Top module: `fault_supervisor`

## Requirements
- R1: After reset every output is low. Both enables go high in the cycle after a clock edge that samples `vdd_on_i` rising, with `vdd_alive_i`, `vdd_run_i` and `line_ok_i` high and no fault latched. Without `line_ok_i` the block does not start.
- R2: When an edge samples `vdd_run_i` low, both enables drop in the next cycle. Switching resumes only on a new rising `vdd_on_i`.
- R3: When an edge samples `vdd_alive_i` low, the next cycle shows the fault flag low, the cause zero, the clamp low and both enables low.
- R4: When `vdd_ovp_i` is high for `VDD_OVP_LEN` consecutive edges, the fault latches one edge later. Any shorter run does not latch.
- R5: When `OUT_OVP_LEN` consecutive strobes on `det_sample_i` each see `out_ovp_i` high, the fault latches one edge after the last strobe. A strobe that sees the flag low restarts the count. The flag has no effect between strobes.
- R6: A run of `temp_latch_i` latches the fault after `TEMP_FAST_LEN` edges if `temp_fast_i` is also high, and after `TEMP_SLOW_LEN` edges otherwise.
- R7: When `overload_i` is high for `OVERLOAD_LEN` consecutive edges, the fault latches. A shorter run does not.
- R8: While the fault is latched, both enables stay low, and `vdd_on_i` edges do not restart the stages.
- R9: `fault_cause_o` records the first fault that latched: 1 supply over-voltage, 2 output over-voltage, 3 temperature, 4 overload, 0 none. If faults complete in the same cycle, the lowest code wins. A later fault does not change the cause.
- R10: When `line_low_i` is high for `LINE_LOW_LEN` consecutive edges, `comp_clamp_o` rises one edge later. `line_ok_i` clears it, and the clamp alone does not stop switching.
- R11: While the clamp is high, an edge that samples `vout_low_i` high drops both enables without latching a fault. Without the clamp, `vout_low_i` has no effect.
- R12: When `light_load_i` is high for `LIGHT_LEN` consecutive edges, `pfc_en_o` drops while `pwm_en_o` stays high. `pfc_en_o` returns in the cycle after an edge that samples the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdd_on_i | input | 1 | Supply above turn-on level |
| vdd_run_i | input | 1 | Supply above PWM-off level |
| vdd_alive_i | input | 1 | Supply above full-reset level |
| vdd_ovp_i | input | 1 | Supply over-voltage |
| det_sample_i | input | 1 | Strobe that samples output over-voltage after blanking |
| out_ovp_i | input | 1 | Output over-voltage flag |
| temp_latch_i | input | 1 | Temperature pin below latch level |
| temp_fast_i | input | 1 | Temperature pin below fast-debounce level |
| overload_i | input | 1 | Feedback above overload level |
| line_low_i | input | 1 | Line below brown-out level |
| line_ok_i | input | 1 | Line above brown-in level |
| vout_low_i | input | 1 | Front-stage output below brownout stop level |
| light_load_i | input | 1 | Light-load request to park the front stage |
| pfc_en_o | output | 1 | Front-stage switching enable |
| pwm_en_o | output | 1 | Back-stage switching enable |
| comp_clamp_o | output | 1 | Clamp request for the error-amplifier output |
| fault_o | output | 1 | Latched fault |
| fault_cause_o | output | 3 | Code of the first latched fault |

## Verification
Two fault debouncers can complete in the same clock cycle. The cause register must then resolve them by fixed priority rather than by order of arrival. The bench provokes this by starting the longer debounce earlier by exactly the difference in lengths, so both counters reach their limits on the same edge. It does this for supply over-voltage against overload, and for slow temperature against overload, and judges the result from the recorded cause code. A further case latches one fault and then completes another, to confirm that the first cause is kept.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int unsigned NUM_TRIP = 4;
  localparam int unsigned CAUSE_W  = $clog2(NUM_TRIP + 1);

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_VDD_OVP  = 3'd1,
    CAUSE_OUT_OVP  = 3'd2,
    CAUSE_TEMP     = 3'd3,
    CAUSE_OVERLOAD = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_LOCK = 2'd2
  } seq_e;
endpackage

// File: rtl/fsup_debounce.sv
module fsup_debounce #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic hit_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(LEN + 1);
  localparam logic [W-1:0] LIM = W'(LEN);

  logic [W-1:0] cnt_q;

  // count consecutive qualified steps; a miss restarts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (step_i) begin
      if (!hit_i)        cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/fsup_temp_guard.sv
module fsup_temp_guard #(
  parameter int unsigned FAST_LEN = 4,
  parameter int unsigned SLOW_LEN = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic latch_lvl_i,
  input  logic fast_lvl_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(SLOW_LEN + 1);
  localparam logic [W-1:0] LIM_SLOW = W'(SLOW_LEN);
  localparam logic [W-1:0] LIM_FAST = W'(FAST_LEN);

  logic [W-1:0] cnt_q;
  logic         fast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      fast_q <= latch_lvl_i & fast_lvl_i;
      if (!latch_lvl_i)          cnt_q <= '0;
      else if (cnt_q != LIM_SLOW) cnt_q <= cnt_q + 1'b1;
    end
  end

  // limit follows the level seen on the latest edge
  assign done_o = fast_q ? (cnt_q >= LIM_FAST) : (cnt_q >= LIM_SLOW);
endmodule

// File: rtl/fsup_trip_latch.sv
module fsup_trip_latch #(
  parameter int unsigned N = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic [N-1:0]               trip_i,
  output logic                       fault_o,
  output logic [$clog2(N+1)-1:0]     cause_o
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] pick;
  logic          fault_q;
  logic [CW-1:0] cause_q;

  // lowest index wins a tie
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (trip_i[i]) pick = CW'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      cause_q <= '0;
    end else if (clr_i) begin
      fault_q <= 1'b0;
      cause_q <= '0;
    end else if (!fault_q && (|trip_i)) begin
      fault_q <= 1'b1;
      cause_q <= pick;
    end
  end

  assign fault_o = fault_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/fsup_sequencer.sv
module fsup_sequencer
  import fsup_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vdd_on_i,
  input  logic vdd_run_i,
  input  logic vdd_alive_i,
  input  logic line_ok_i,
  input  logic uv_trip_i,
  input  logic vout_low_i,
  input  logic fault_i,
  input  logic light_i,
  output logic pwm_en_o,
  output logic pfc_en_o,
  output logic clamp_o
);
  seq_e st_q, st_d;
  logic on_q;
  logic uv_q;
  logic on_rise;
  logic bo_stop;

  assign on_rise = vdd_on_i & ~on_q;
  assign bo_stop = uv_q & vout_low_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF: begin
        if (fault_i) st_d = ST_LOCK;
        else if (vdd_alive_i && vdd_run_i && line_ok_i && on_rise) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (fault_i) st_d = ST_LOCK;
        else if (!vdd_alive_i || !vdd_run_i || bo_stop) st_d = ST_OFF;
      end
      ST_LOCK: begin
        if (!vdd_alive_i) st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OFF;
      on_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      on_q <= vdd_on_i;
      if (!vdd_alive_i || line_ok_i) uv_q <= 1'b0;
      else if (uv_trip_i)            uv_q <= 1'b1;
    end
  end

  assign pwm_en_o = (st_q == ST_RUN) & ~fault_i;
  assign pfc_en_o = pwm_en_o & ~light_i;
  assign clamp_o  = uv_q;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned VDD_OVP_LEN   = 37500,
  parameter int unsigned OUT_OVP_LEN   = 3,
  parameter int unsigned TEMP_FAST_LEN = 25000,
  parameter int unsigned TEMP_SLOW_LEN = 2500000,
  parameter int unsigned OVERLOAD_LEN  = 12500000,
  parameter int unsigned LINE_LOW_LEN  = 25000000,
  parameter int unsigned LIGHT_LEN     = 125000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vdd_on_i,
  input  logic       vdd_run_i,
  input  logic       vdd_alive_i,
  input  logic       vdd_ovp_i,
  input  logic       det_sample_i,
  input  logic       out_ovp_i,
  input  logic       temp_latch_i,
  input  logic       temp_fast_i,
  input  logic       overload_i,
  input  logic       line_low_i,
  input  logic       line_ok_i,
  input  logic       vout_low_i,
  input  logic       light_load_i,
  output logic       pfc_en_o,
  output logic       pwm_en_o,
  output logic       comp_clamp_o,
  output logic       fault_o,
  output logic [2:0] fault_cause_o
);
  localparam int unsigned NUM_DB = 4;
  localparam int unsigned DB_LEN [NUM_DB] = '{VDD_OVP_LEN, OVERLOAD_LEN, LINE_LOW_LEN, LIGHT_LEN};

  logic               full_rst;
  logic [NUM_DB-1:0]  db_hit;
  logic [NUM_DB-1:0]  db_done;
  logic               oov_done;
  logic               temp_done;
  logic [NUM_TRIP-1:0] trips;
  logic               fault;
  logic [CAUSE_W-1:0] cause;

  assign full_rst = ~vdd_alive_i;
  assign db_hit   = {light_load_i, line_low_i, overload_i, vdd_ovp_i};

  for (genvar g = 0; g < NUM_DB; g++) begin : g_db
    fsup_debounce #(.LEN(DB_LEN[g])) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (full_rst),
      .step_i (1'b1),
      .hit_i  (db_hit[g]),
      .done_o (db_done[g])
    );
  end

  fsup_debounce #(.LEN(OUT_OVP_LEN)) u_oov (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (full_rst),
    .step_i (det_sample_i),
    .hit_i  (out_ovp_i),
    .done_o (oov_done)
  );

  fsup_temp_guard #(.FAST_LEN(TEMP_FAST_LEN), .SLOW_LEN(TEMP_SLOW_LEN)) u_temp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (full_rst),
    .latch_lvl_i (temp_latch_i),
    .fast_lvl_i  (temp_fast_i),
    .done_o      (temp_done)
  );

  // bit order sets tie priority and cause code
  assign trips = {db_done[1], temp_done, oov_done, db_done[0]};

  fsup_trip_latch #(.N(NUM_TRIP)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (full_rst),
    .trip_i  (trips),
    .fault_o (fault),
    .cause_o (cause)
  );

  fsup_sequencer u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vdd_on_i    (vdd_on_i),
    .vdd_run_i   (vdd_run_i),
    .vdd_alive_i (vdd_alive_i),
    .line_ok_i   (line_ok_i),
    .uv_trip_i   (db_done[2]),
    .vout_low_i  (vout_low_i),
    .fault_i     (fault),
    .light_i     (db_done[3]),
    .pwm_en_o    (pwm_en_o),
    .pfc_en_o    (pfc_en_o),
    .clamp_o     (comp_clamp_o)
  );

  assign fault_o       = fault;
  assign fault_cause_o = cause;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vdd_on_i,
  input logic       vdd_alive_i,
  input logic       line_ok_i,
  input logic       pfc_en_o,
  input logic       pwm_en_o,
  input logic       comp_clamp_o,
  input logic       fault_o,
  input logic [2:0] fault_cause_o
);
  assert_start_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_en_o) |-> ($past(vdd_on_i) && $past(line_ok_i)));

  assert_full_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vdd_alive_i |=> (!fault_o && !comp_clamp_o && !pwm_en_o && fault_cause_o == 3'd0));

  assert_lock_gates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!pwm_en_o && !pfc_en_o));

  assert_cause_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && vdd_alive_i) |=> (fault_o && $stable(fault_cause_o)));

  assert_cause_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_cause_o >= 3'd1 && fault_cause_o <= 3'd4));

  assert_pfc_needs_pwm_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfc_en_o |-> pwm_en_o);
endmodule

bind fault_supervisor fsup_checker u_fsup_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .vdd_on_i      (vdd_on_i),
  .vdd_alive_i   (vdd_alive_i),
  .line_ok_i     (line_ok_i),
  .pfc_en_o      (pfc_en_o),
  .pwm_en_o      (pwm_en_o),
  .comp_clamp_o  (comp_clamp_o),
  .fault_o       (fault_o),
  .fault_cause_o (fault_cause_o)
);

// File: tb/fault_supervisor_bench.sv
`timescale 1ns/1ps
module fault_supervisor_bench;
  localparam int VOV = 6;
  localparam int OOV = 3;
  localparam int TF  = 4;
  localparam int TS  = 12;
  localparam int OL  = 10;
  localparam int LU  = 8;
  localparam int LP  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vdd_on = 0, vdd_run = 0, vdd_alive = 0, vdd_ovp = 0, det_sample = 0, out_ovp = 0;
  logic temp_latch = 0, temp_fast = 0, overload = 0, line_low = 0, line_ok = 0, vout_low = 0, light_load = 0;
  logic pfc_en, pwm_en, clamp, fault;
  logic [2:0] cause;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fault_supervisor #(
    .VDD_OVP_LEN(VOV), .OUT_OVP_LEN(OOV), .TEMP_FAST_LEN(TF), .TEMP_SLOW_LEN(TS),
    .OVERLOAD_LEN(OL), .LINE_LOW_LEN(LU), .LIGHT_LEN(LP)
  ) u_fault_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .vdd_on_i(vdd_on), .vdd_run_i(vdd_run), .vdd_alive_i(vdd_alive),
    .vdd_ovp_i(vdd_ovp), .det_sample_i(det_sample), .out_ovp_i(out_ovp), .temp_latch_i(temp_latch),
    .temp_fast_i(temp_fast), .overload_i(overload), .line_low_i(line_low), .line_ok_i(line_ok),
    .vout_low_i(vout_low), .light_load_i(light_load), .pfc_en_o(pfc_en), .pwm_en_o(pwm_en),
    .comp_clamp_o(clamp), .fault_o(fault), .fault_cause_o(cause)
  );

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic full_off();
    vdd_on = 0; vdd_run = 0; vdd_alive = 0; vdd_ovp = 0; det_sample = 0; out_ovp = 0;
    temp_latch = 0; temp_fast = 0; overload = 0; line_low = 0; line_ok = 0; vout_low = 0; light_load = 0;
    tick(2);
  endtask

  task automatic power_up();
    vdd_alive = 1; vdd_run = 1; line_ok = 1; vdd_on = 0;
    tick(1);
    vdd_on = 1;
    tick(1);
    vdd_on = 0;
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 reset pwm", pwm_en, 0);
    chk("R1 reset pfc", pfc_en, 0);
    chk("R1 reset fault", fault, 0);
    chk("R1 reset cause", cause, 0);
    chk("R1 reset clamp", clamp, 0);

    // R1: no start without brown-in, then a good start
    vdd_alive = 1; vdd_run = 1; line_ok = 0;
    tick(1);
    vdd_on = 1;
    tick(1);
    chk("R1 no line no start", pwm_en, 0);
    vdd_on = 0; line_ok = 1;
    tick(1);
    vdd_on = 1;
    tick(1);
    chk("R1 start pwm", pwm_en, 1);
    chk("R1 start pfc", pfc_en, 1);
    vdd_on = 0;
    tick(1);

    // R2: PWM-off level stops, restart needs a new crossing
    vdd_run = 0;
    tick(1);
    chk("R2 stop pwm", pwm_en, 0);
    chk("R2 stop pfc", pfc_en, 0);
    vdd_run = 1;
    tick(3);
    chk("R2 no restart without crossing", pwm_en, 0);
    vdd_on = 1;
    tick(1);
    chk("R2 restart", pwm_en, 1);
    full_off();

    // R4 sweep on supply over-voltage length
    for (int n = 1; n <= VOV + 1; n++) begin
      power_up();
      vdd_ovp = 1;
      tick(n);
      vdd_ovp = 0;
      tick(1);
      chk("R4 vdd ovp fault", fault, (n >= VOV) ? 1 : 0);
      chk("R4 vdd ovp pwm", pwm_en, (n >= VOV) ? 0 : 1);
      if (n >= VOV) begin
        chk("R9 cause vdd ovp", cause, 1);
        // R8: turn-on edge does not restart a latched block
        vdd_on = 1; tick(1); vdd_on = 0; tick(2);
        chk("R8 locked pwm", pwm_en, 0);
        chk("R8 locked pfc", pfc_en, 0);
        chk("R8 fault held", fault, 1);
        vdd_alive = 0; vdd_run = 0;
        tick(1);
        chk("R3 fault cleared", fault, 0);
        chk("R3 cause cleared", cause, 0);
      end
      full_off();
    end

    // R5 sweep on strobe count
    for (int n = 1; n <= OOV + 1; n++) begin
      power_up();
      out_ovp = 1;
      for (int k = 0; k < n; k++) begin
        det_sample = 1; tick(1); det_sample = 0; tick(2);
      end
      out_ovp = 0;
      chk("R5 out ovp fault", fault, (n >= OOV) ? 1 : 0);
      if (n >= OOV) chk("R9 cause out ovp", cause, 2);
      full_off();
    end
    power_up();
    out_ovp = 1;
    tick(40);
    chk("R5 flag without strobe", fault, 0);
    for (int k = 0; k < 2 * OOV - 1; k++) begin
      out_ovp = (k != OOV - 1);
      det_sample = 1; tick(1); det_sample = 0; tick(1);
    end
    out_ovp = 0;
    tick(2);
    chk("R5 low strobe restarts count", fault, 0);
    full_off();

    // R6 fast and slow temperature debounce
    for (int n = TF - 1; n <= TF; n++) begin
      power_up();
      temp_latch = 1; temp_fast = 1;
      tick(n);
      temp_latch = 0; temp_fast = 0;
      tick(1);
      chk("R6 fast temp fault", fault, (n == TF) ? 1 : 0);
      if (n == TF) chk("R9 cause temp", cause, 3);
      full_off();
    end
    for (int n = TS - 1; n <= TS; n++) begin
      power_up();
      temp_latch = 1;
      tick(n);
      temp_latch = 0;
      tick(1);
      chk("R6 slow temp fault", fault, (n == TS) ? 1 : 0);
      full_off();
    end

    // R7 overload
    for (int n = OL - 1; n <= OL; n++) begin
      power_up();
      overload = 1;
      tick(n);
      overload = 0;
      tick(1);
      chk("R7 overload fault", fault, (n == OL) ? 1 : 0);
      if (n == OL) chk("R9 cause overload", cause, 4);
      full_off();
    end

    // R9 same-cycle completion and first-wins
    power_up();
    overload = 1; tick(OL - VOV);
    vdd_ovp = 1; tick(VOV);
    overload = 0; vdd_ovp = 0; tick(1);
    chk("R9 tie supply over overload", cause, 1);
    full_off();
    power_up();
    temp_latch = 1; tick(TS - OL);
    overload = 1; tick(OL);
    temp_latch = 0; overload = 0; tick(1);
    chk("R9 tie temp over overload", cause, 3);
    full_off();
    power_up();
    overload = 1; tick(OL); overload = 0; tick(1);
    vdd_ovp = 1; tick(VOV + 2); vdd_ovp = 0; tick(1);
    chk("R9 first cause kept", cause, 4);
    full_off();

    // R10 line brown-out clamp
    for (int n = LU - 1; n <= LU; n++) begin
      power_up();
      line_ok = 0; line_low = 1;
      tick(n);
      line_low = 0;
      tick(1);
      chk("R10 clamp", clamp, (n == LU) ? 1 : 0);
      chk("R10 clamp keeps switching", pwm_en, 1);
      line_ok = 1;
      tick(1);
      chk("R10 brown-in clears clamp", clamp, 0);
      full_off();
    end

    // R11 brownout stop and restart
    power_up();
    vout_low = 1; tick(2);
    chk("R11 no clamp no stop", pwm_en, 1);
    vout_low = 0;
    line_ok = 0; line_low = 1;
    tick(LU + 1);
    chk("R11 clamp up", clamp, 1);
    vout_low = 1;
    tick(1);
    chk("R11 stop pwm", pwm_en, 0);
    chk("R11 stop pfc", pfc_en, 0);
    chk("R11 not latched", fault, 0);
    vout_low = 0;
    vdd_on = 1; tick(1); vdd_on = 0; tick(1);
    chk("R11 no restart without brown-in", pwm_en, 0);
    line_low = 0; line_ok = 1;
    tick(1);
    vdd_on = 1; tick(1); vdd_on = 0;
    chk("R11 restart", pwm_en, 1);
    line_ok = 0; line_low = 1;
    tick(LU + 1);
    vdd_alive = 0;
    tick(1);
    chk("R3 clamp cleared", clamp, 0);
    full_off();

    // R12 light-load parking of the front stage
    for (int n = LP - 1; n <= LP; n++) begin
      power_up();
      light_load = 1;
      tick(n);
      chk("R12 pfc parked", pfc_en, (n == LP) ? 0 : 1);
      chk("R12 pwm unaffected", pwm_en, 1);
      light_load = 0;
      tick(1);
      chk("R12 pfc back", pfc_en, 1);
      full_off();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule